// File: doc/BRIEF.md
# Cache Tag Timing Model

This block models the timing of a set-associative cache without holding any line data. It keeps tags, valid bits, dirty bits and replacement ages for many simulated cores. Each core has two private tag arrays, one for instruction fetches and one for data accesses. Every accepted lookup carries a core number, an instruction/data select, an address and a write flag. One cycle later the block returns hit or miss, whether a dirty victim has to be written back, and the number of target cycles to charge for the access. A performance-counting layer can use these outputs directly.

The number of sets, the number of ways and the block size are all powers of two. They are loaded as base-2 logarithms through a configuration port, together with three latencies. Each value is bounded by a compile-time maximum. All ways of the indexed set are compared in the same cycle. On a miss the new tag is installed in place of the victim. Loading a new configuration drops every stored tag, so the geometry can change without rebuilding the hardware.

Top module: `cache_tag_timer`

## Requirements
- R1: After reset, `rsp_valid` is low and every tag entry is invalid. The geometry is one set, one way and a one-byte block. The hit latency and the miss latency are both 1, and the writeback latency is 0.
- R2: A lookup offered while `cfg_we` is low produces a response with `rsp_valid` high on the following cycle. A lookup offered in the same cycle as `cfg_we` is dropped and gives no response.
- R3: A lookup hits when a valid, active way of the indexed set holds its tag. Exactly one of `rsp_hit` and `rsp_miss` is high in every response.
- R4: The set index is `(addr >> blk_lg) mod 2^sets_lg`. The tag is `addr >> (blk_lg + sets_lg)`. Only ways 0 to 2^ways_lg-1 are active. A programmed log value above its maximum is clamped to that maximum.
- R5: A miss installs the tag. A read miss leaves the line clean and a write miss leaves it dirty. A write hit marks the line dirty, and a read hit leaves the dirty bit unchanged.
- R6: `rsp_wb` is high exactly when a miss evicts a line that is both valid and dirty.
- R7: The victim is the lowest-numbered invalid active way if one exists. Otherwise it is the least recently used active way. Both hits and installs count as a use.
- R8: `rsp_lat` equals the hit latency on a hit and the miss latency on a miss. When `rsp_wb` is high, the writeback latency is added to the miss latency.
- R9: Each core's instruction array and data array are separate. A tag installed in one array never produces a hit in another.
- R10: A configuration write invalidates all entries. The new geometry and latencies apply from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load configuration and invalidate all entries |
| cfg_sets_lg | input | 2 | log2 of the number of sets |
| cfg_ways_lg | input | 2 | log2 of the associativity |
| cfg_blk_lg | input | 2 | log2 of the block size in bytes |
| cfg_hit_lat | input | 8 | Latency charged on a hit |
| cfg_miss_lat | input | 8 | Latency charged on a miss |
| cfg_wb_lat | input | 8 | Extra latency charged for a dirty eviction |
| req_valid | input | 1 | Lookup request |
| req_core | input | 2 | Simulated core number |
| req_inst | input | 1 | 1 selects the instruction array, 0 the data array |
| req_write | input | 1 | Lookup is a store |
| req_addr | input | 16 | Byte address |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_miss | output | 1 | Lookup missed |
| rsp_wb | output | 1 | Dirty victim evicted |
| rsp_lat | output | 9 | Target cycles to charge |

## Verification
The bench sweeps every programmable geometry, including the clamped encodings, with two block sizes. Under each geometry it first runs ascending block-stride addresses spanning twice the capacity, as reads and then as writes. This pattern shows whether the set index and tag are split at the right bit, and whether LRU eviction thrashes the way it should. It then runs a pseudo-random mix of cores, instruction/data arrays and read/write flags over a narrow address range. That mix separates the dirty and writeback paths and shows any leak between private arrays. Short targeted sequences cover the reset state, the drop of a request that arrives with a configuration write, LRU order, array privacy, and the invalidation on reconfiguration.

// File: rtl/cache_tag_timer.sv
module cache_tag_timer #(
  parameter int CORES       = 4,
  parameter int ADDR_W      = 16,
  parameter int SETS_LG_MAX = 2,
  parameter int WAYS_LG_MAX = 2,
  parameter int BLK_LG_MAX  = 3,
  parameter int LAT_W       = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cfg_we,
  input  logic [$clog2(SETS_LG_MAX+1)-1:0]   cfg_sets_lg,
  input  logic [$clog2(WAYS_LG_MAX+1)-1:0]   cfg_ways_lg,
  input  logic [$clog2(BLK_LG_MAX+1)-1:0]    cfg_blk_lg,
  input  logic [LAT_W-1:0]                   cfg_hit_lat,
  input  logic [LAT_W-1:0]                   cfg_miss_lat,
  input  logic [LAT_W-1:0]                   cfg_wb_lat,
  input  logic                               req_valid,
  input  logic [$clog2(CORES)-1:0]           req_core,
  input  logic                               req_inst,
  input  logic                               req_write,
  input  logic [ADDR_W-1:0]                  req_addr,
  output logic                               rsp_valid,
  output logic                               rsp_hit,
  output logic                               rsp_miss,
  output logic                               rsp_wb,
  output logic [LAT_W:0]                     rsp_lat
);
  localparam int SLW  = $clog2(SETS_LG_MAX+1);
  localparam int WLW  = $clog2(WAYS_LG_MAX+1);
  localparam int BLW  = $clog2(BLK_LG_MAX+1);
  localparam int CW   = $clog2(CORES);
  localparam int WAYS = 1 << WAYS_LG_MAX;
  localparam int AGW  = (WAYS_LG_MAX > 0) ? WAYS_LG_MAX : 1;
  localparam int EW   = CW + 1 + SETS_LG_MAX;
  localparam int ENT  = 1 << EW;

  logic [SLW-1:0]   sets_lg_q;
  logic [WLW-1:0]   ways_lg_q;
  logic [BLW-1:0]   blk_lg_q;
  logic [LAT_W-1:0] hit_lat_q, miss_lat_q, wb_lat_q;

  logic [ADDR_W-1:0] tag_q [ENT][WAYS];
  logic [WAYS-1:0]   vld_q [ENT];
  logic [WAYS-1:0]   dty_q [ENT];
  logic [AGW-1:0]    age_q [ENT][WAYS];

  wire                     acc      = req_valid && !cfg_we;
  wire [ADDR_W-1:0]        blk_addr = req_addr >> blk_lg_q;
  wire [ADDR_W-1:0]        req_tag  = blk_addr >> sets_lg_q;
  wire [SETS_LG_MAX-1:0]   set_mask = ~({SETS_LG_MAX{1'b1}} << sets_lg_q);
  wire [SETS_LG_MAX-1:0]   set_idx  = blk_addr[SETS_LG_MAX-1:0] & set_mask;
  wire [EW-1:0]            ent      = {req_core, req_inst, set_idx};
  wire [AGW-1:0]           oldest   = ~({AGW{1'b1}} << ways_lg_q);

  logic [WAYS-1:0] act;
  logic            hit, inv_found, wb;
  logic [AGW-1:0]  hway, iway, lway, vway, sel;

  always_comb begin
    hit = 1'b0; hway = '0; inv_found = 1'b0; iway = '0; lway = '0;
    for (int w = 0; w < WAYS; w++) begin
      act[w] = ((w >> ways_lg_q) == 0);
      if (act[w] && vld_q[ent][w] && tag_q[ent][w] == req_tag && !hit) begin
        hit = 1'b1; hway = AGW'(w);
      end
      if (act[w] && age_q[ent][w] == oldest) lway = AGW'(w);
    end
    for (int w = WAYS-1; w >= 0; w--)
      if (act[w] && !vld_q[ent][w]) begin
        inv_found = 1'b1; iway = AGW'(w);
      end
    vway = inv_found ? iway : lway;
    sel  = hit ? hway : vway;
    wb   = !hit && vld_q[ent][vway] && dty_q[ent][vway];
  end

  assign rsp_miss = rsp_valid && !rsp_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sets_lg_q <= '0; ways_lg_q <= '0; blk_lg_q <= '0;
      hit_lat_q <= LAT_W'(1); miss_lat_q <= LAT_W'(1); wb_lat_q <= '0;
      rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_wb <= 1'b0; rsp_lat <= '0;
      for (int e = 0; e < ENT; e++) begin
        vld_q[e] <= '0; dty_q[e] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tag_q[e][w] <= '0; age_q[e][w] <= AGW'(w);
        end
      end
    end else begin
      rsp_valid <= acc;
      rsp_hit   <= acc && hit;
      rsp_wb    <= acc && wb;
      rsp_lat   <= hit ? {1'b0, hit_lat_q}
                       : ({1'b0, miss_lat_q} + (wb ? {1'b0, wb_lat_q} : '0));
      if (cfg_we) begin
        sets_lg_q  <= (cfg_sets_lg > SLW'(SETS_LG_MAX)) ? SLW'(SETS_LG_MAX) : cfg_sets_lg;
        ways_lg_q  <= (cfg_ways_lg > WLW'(WAYS_LG_MAX)) ? WLW'(WAYS_LG_MAX) : cfg_ways_lg;
        blk_lg_q   <= (cfg_blk_lg  > BLW'(BLK_LG_MAX))  ? BLW'(BLK_LG_MAX)  : cfg_blk_lg;
        hit_lat_q  <= cfg_hit_lat;
        miss_lat_q <= cfg_miss_lat;
        wb_lat_q   <= cfg_wb_lat;
        for (int e = 0; e < ENT; e++) begin
          vld_q[e] <= '0; dty_q[e] <= '0;
          for (int w = 0; w < WAYS; w++) age_q[e][w] <= AGW'(w);
        end
      end else if (acc) begin
        tag_q[ent][sel] <= req_tag;
        vld_q[ent][sel] <= 1'b1;
        dty_q[ent][sel] <= hit ? (dty_q[ent][sel] | req_write) : req_write;
        for (int w = 0; w < WAYS; w++)
          if (act[w]) begin
            if (AGW'(w) == sel) age_q[ent][w] <= '0;
            else if (age_q[ent][w] < age_q[ent][sel]) age_q[ent][w] <= age_q[ent][w] + 1'b1;
          end
      end
    end
  end

  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);
  p_drop_on_cfg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !rsp_valid);
  p_wb_only_on_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_wb |-> (rsp_valid && !rsp_hit));
  p_hit_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_lat == {1'b0, hit_lat_q});
  p_write_hit_dirty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && hit && req_write) |=> dty_q[$past(ent)][$past(sel)]);
  p_cfg_invalidates_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (vld_q[0] == '0));
endmodule

// File: tb/cache_tag_timer_tb.sv
`timescale 1ns/1ps
module cache_tag_timer_tb;
  localparam int NC = 4, NS = 4, NW = 4;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_sets_lg = 0, cfg_ways_lg = 0, cfg_blk_lg = 0;
  logic [7:0] cfg_hit_lat = 0, cfg_miss_lat = 0, cfg_wb_lat = 0;
  logic req_valid = 0, req_inst = 0, req_write = 0;
  logic [1:0] req_core = 0;
  logic [15:0] req_addr = 0;
  logic rsp_valid, rsp_hit, rsp_miss, rsp_wb;
  logic [8:0] rsp_lat;

  int checks = 0, errors = 0;
  int msl = 0, mwl = 0, mbl = 0, mhl = 1, mml = 1, mwbl = 0, now = 0;
  logic [15:0] mt [NC][2][NS][NW];
  bit mv [NC][2][NS][NW];
  bit md [NC][2][NS][NW];
  int mts [NC][2][NS][NW];

  always #5 clk = ~clk;

  cache_tag_timer u_dut (
    .clk, .rst_n, .cfg_we, .cfg_sets_lg, .cfg_ways_lg, .cfg_blk_lg,
    .cfg_hit_lat, .cfg_miss_lat, .cfg_wb_lat, .req_valid, .req_core,
    .req_inst, .req_write, .req_addr, .rsp_valid, .rsp_hit, .rsp_miss,
    .rsp_wb, .rsp_lat);

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic mclear();
    for (int c = 0; c < NC; c++) for (int s = 0; s < 2; s++)
      for (int i = 0; i < NS; i++) for (int w = 0; w < NW; w++) begin
        mv[c][s][i][w] = 0; md[c][s][i][w] = 0; mts[c][s][i][w] = 0;
      end
  endtask

  task automatic cfg(int sl, int wl, int bl, int hl, int ml, int wbl, bit with_req);
    cfg_we = 1; cfg_sets_lg = 2'(sl); cfg_ways_lg = 2'(wl); cfg_blk_lg = 2'(bl);
    cfg_hit_lat = 8'(hl); cfg_miss_lat = 8'(ml); cfg_wb_lat = 8'(wbl);
    req_valid = with_req;
    @(negedge clk);
    cfg_we = 0; req_valid = 0;
    chk(rsp_valid == 0, "R2 no response in cfg cycle", int'(rsp_valid), 0);
    mclear();
    msl = (sl > 2) ? 2 : sl; mwl = (wl > 2) ? 2 : wl; mbl = bl;
    mhl = hl; mml = ml; mwbl = wbl;
  endtask

  task automatic req(int core, bit inst, bit wr, logic [15:0] a, string ph);
    int si, nw, hw, vw, elat;
    bit eh, ewb, found;
    logic [15:0] tg;
    si = int'(a >> mbl) & ((1 << msl) - 1);
    tg = a >> (mbl + msl);
    nw = 1 << mwl;
    eh = 0; hw = 0;
    for (int w = 0; w < nw; w++)
      if (!eh && mv[core][inst][si][w] && mt[core][inst][si][w] == tg) begin eh = 1; hw = w; end
    found = 0; vw = 0;
    for (int w = 0; w < nw; w++)
      if (!found && !mv[core][inst][si][w]) begin found = 1; vw = w; end
    if (!found)
      for (int w = 1; w < nw; w++)
        if (mts[core][inst][si][w] < mts[core][inst][si][vw]) vw = w;
    ewb = !eh && mv[core][inst][si][vw] && md[core][inst][si][vw];
    elat = eh ? mhl : mml + (ewb ? mwbl : 0);
    if (eh) vw = hw;
    now++;
    mt[core][inst][si][vw] = tg;
    md[core][inst][si][vw] = eh ? (md[core][inst][si][vw] | wr) : wr;
    mv[core][inst][si][vw] = 1;
    mts[core][inst][si][vw] = now;

    req_valid = 1; req_core = 2'(core); req_inst = inst; req_write = wr; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid == 1, {ph, " R2 response valid"}, int'(rsp_valid), 1);
    chk(rsp_hit == eh && rsp_miss == !eh, {ph, " R3 hit/miss"}, int'(rsp_hit), int'(eh));
    chk(rsp_wb == ewb, {ph, " R6 writeback"}, int'(rsp_wb), int'(ewb));
    chk(int'(rsp_lat) == elat, {ph, " R8 latency"}, int'(rsp_lat), elat);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    mclear();
    repeat (3) @(negedge clk);
    chk(rsp_valid == 0 && rsp_wb == 0, "R1 reset outputs", int'(rsp_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk(rsp_valid == 0, "R1 idle after reset", int'(rsp_valid), 0);
    req(0, 0, 0, 16'h0040, "R1 reset first miss");
    req(0, 0, 1, 16'h0040, "R1 reset second hit");
    req(0, 0, 0, 16'h0041, "R1 one-way evict R5");

    cfg(0, 1, 0, 2, 9, 4, 1);
    req(0, 0, 0, 16'h0010, "R7 lru");
    req(0, 0, 0, 16'h0020, "R7 lru");
    req(0, 0, 0, 16'h0010, "R7 lru");
    req(0, 0, 0, 16'h0030, "R7 lru evicts 20");
    req(0, 0, 0, 16'h0020, "R7 lru 20 misses");
    req(0, 0, 0, 16'h0030, "R7 lru 30 hits");

    req(1, 0, 1, 16'h0100, "R9 private");
    req(1, 1, 0, 16'h0100, "R9 private inst");
    req(2, 0, 0, 16'h0100, "R9 private core");
    req(1, 0, 0, 16'h0100, "R9 private own");

    cfg(0, 1, 0, 2, 9, 4, 0);
    req(1, 0, 0, 16'h0100, "R10 clear");

    seed = 32'h1234_5678;
    for (int sl = 0; sl < 4; sl++)
      for (int wl = 0; wl < 4; wl++)
        for (int bi = 0; bi < 2; bi++) begin
          int bl, cap;
          bl = bi * 2;
          cfg(sl, wl, bl, 1 + sl, 20 + wl, 7, bi[0]);
          cap = (1 << msl) * (1 << mwl);
          for (int rep = 0; rep < 2; rep++)
            for (int i = 0; i < 2 * cap; i++)
              req(0, 0, rep[0], 16'(i << bl), "R4 sweep R7");
          for (int i = 0; i < 48; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            req(int'(seed[29:28]), seed[30], seed[31],
                16'(seed[23:16] & 8'h3F) ^ (16'(seed[25:24]) << 12), "R5 mix R9");
          end
        end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule